// File: doc/BRIEF.md
# Transactional-Write Synchronous FIFO

This is a single-clock FIFO whose write side works in transactions. Each word accepted by `put_i` takes a storage slot at once. The reader cannot see that word until the writer issues `commit_i`. If the writer issues `rollback_i` instead, every word written since the last commit or rollback is dropped and its slot becomes free again. Because tentative words hold storage that the reader cannot reach, the FIFO can show `full_o` high while `valid_o` is low.

The read side works in first-word-fall-through mode. The oldest committed word sits on `dout_o` whenever `valid_o` is high, and `got_i` pops it. Each side also has a coarse level output, computed combinationally from the pointer difference. On the read side it gives the fraction of the capacity that is committed and readable. On the write side it gives the fraction that is guaranteed free. A level width of zero turns that output off, and it then stays at zero. The requested depth is rounded up to a power of two.

Top module: `txn_fifo`

## Requirements
- R1: After reset is asserted (`rst_ni` low), `valid_o` and `full_o` are 0, `fill_lvl_o` is 0 and `free_lvl_o` is at its maximum value (all ones).
- R2: Words accepted by `put_i` without a commit never raise `valid_o` and are never presented on `dout_o`.
- R3: A commit makes every pending word readable, including a put in the same cycle, and the words are read out in write order.
- R4: A rollback discards every pending word, including a put in the same cycle. It frees their slots and leaves committed words untouched.
- R5: `full_o` is high exactly when committed plus pending words equal the capacity, whether or not those words are committed.
- R6: A put while `full_o` is high is ignored and does not change the stored data.
- R7: A got while `valid_o` is low is ignored.
- R8: A put and a got in the same cycle, when the FIFO is neither full nor empty, both take effect.
- R9: `fill_lvl_o` equals floor(committed × 2^FILL_BITS / capacity), saturated at 2^FILL_BITS − 1.
- R10: `free_lvl_o` equals floor((capacity − committed − pending) × 2^FREE_BITS / capacity), saturated at 2^FREE_BITS − 1.
- R11: The capacity is MIN_DEPTH rounded up to a power of two, so MIN_DEPTH = 12 holds exactly 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| put_i | input | 1 | Write a word tentatively |
| din_i | input | DATA_W | Write data |
| commit_i | input | 1 | Publish all pending words |
| rollback_i | input | 1 | Discard all pending words |
| full_o | output | 1 | No free slot |
| free_lvl_o | output | max(1,FREE_BITS) | Guaranteed free space, quantized |
| got_i | input | 1 | Pop the word on dout_o |
| dout_o | output | DATA_W | Oldest committed word |
| valid_o | output | 1 | dout_o holds a committed word |
| fill_lvl_o | output | max(1,FILL_BITS) | Committed fill, quantized |

## Verification
All pointers are registered, and every output is a combinational function of those registers. The effect of a put, got, commit or rollback sampled at a rising edge therefore shows on `valid_o`, `full_o`, `dout_o` and both level outputs right after that same edge, with one cycle of latency and no more. The bench drives its stimulus at the falling edge and waits through one rising edge. It compares every output against a queue model at the next falling edge, before the next stimulus is applied.

// File: rtl/txn_fifo_pkg.sv
package txn_fifo_pkg;
  function automatic int unsigned lvl_w(input int unsigned bits);
    return (bits == 0) ? 1 : bits;
  endfunction

  function automatic int unsigned addr_w(input int unsigned min_depth);
    return (min_depth <= 2) ? 1 : $clog2(min_depth);
  endfunction
endpackage

// File: rtl/txn_fifo_mem.sv
module txn_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txn_fifo_ptrs.sv
module txn_fifo_ptrs #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            put_i,
  input  logic            got_i,
  input  logic            commit_i,
  input  logic            rollback_i,
  output logic            we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic            full_o,
  output logic            valid_o,
  output logic [ADDR_W:0] fill_cnt_o,
  output logic [ADDR_W:0] free_cnt_o
);
  localparam int unsigned PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;

  logic [PW-1:0] rd_q, cmt_q, tnt_q, tnt_nxt;
  logic do_put, do_got;

  assign full_o  = (tnt_q[ADDR_W] != rd_q[ADDR_W]) &&
                   (tnt_q[ADDR_W-1:0] == rd_q[ADDR_W-1:0]);
  assign valid_o = (rd_q != cmt_q);
  assign do_put  = put_i && !full_o;
  assign do_got  = got_i && valid_o;
  assign tnt_nxt = tnt_q + PW'(do_put);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      cmt_q <= '0;
      tnt_q <= '0;
    end else begin
      if (do_got) rd_q <= rd_q + PW'(1);
      if (rollback_i) begin
        tnt_q <= cmt_q;            // drops a same-cycle put as well
      end else begin
        tnt_q <= tnt_nxt;
        if (commit_i) cmt_q <= tnt_nxt;  // publishes a same-cycle put
      end
    end
  end

  assign we_o       = do_put;
  assign waddr_o    = tnt_q[ADDR_W-1:0];
  assign raddr_o    = rd_q[ADDR_W-1:0];
  assign fill_cnt_o = cmt_q - rd_q;
  assign free_cnt_o = DEPTH_P - (tnt_q - rd_q);
endmodule

// File: rtl/txn_fifo_level.sv
module txn_fifo_level #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BITS   = 2,
  parameter int unsigned OUT_W  = 2
) (
  input  logic [ADDR_W:0]  cnt_i,
  output logic [OUT_W-1:0] lvl_o
);
  generate
    if (BITS == 0) begin : g_off
      assign lvl_o = '0;
    end else begin : g_on
      localparam int unsigned SH = ADDR_W - BITS;
      localparam logic [ADDR_W:0] MAXV = (ADDR_W+1)'((1 << BITS) - 1);
      logic [ADDR_W:0] shifted;
      assign shifted = cnt_i >> SH;
      assign lvl_o = (shifted > MAXV) ? MAXV[OUT_W-1:0] : shifted[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/txn_fifo.sv
module txn_fifo
  import txn_fifo_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MIN_DEPTH = 12,
  parameter int unsigned FILL_BITS = 2,
  parameter int unsigned FREE_BITS = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  put_i,
  input  logic [DATA_W-1:0]                     din_i,
  input  logic                                  commit_i,
  input  logic                                  rollback_i,
  output logic                                  full_o,
  output logic [(FREE_BITS>0?FREE_BITS:1)-1:0]  free_lvl_o,
  input  logic                                  got_i,
  output logic [DATA_W-1:0]                     dout_o,
  output logic                                  valid_o,
  output logic [(FILL_BITS>0?FILL_BITS:1)-1:0]  fill_lvl_o
);
  localparam int unsigned ADDR_W  = addr_w(MIN_DEPTH);
  localparam int unsigned FILL_B  = (FILL_BITS > ADDR_W) ? ADDR_W : FILL_BITS;
  localparam int unsigned FREE_B  = (FREE_BITS > ADDR_W) ? ADDR_W : FREE_BITS;
  localparam int unsigned FILL_OW = lvl_w(FILL_BITS);
  localparam int unsigned FREE_OW = lvl_w(FREE_BITS);

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   fill_cnt, free_cnt;

  txn_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .put_i      (put_i),
    .got_i      (got_i),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .full_o     (full_o),
    .valid_o    (valid_o),
    .fill_cnt_o (fill_cnt),
    .free_cnt_o (free_cnt)
  );

  txn_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (din_i),
    .raddr_i (raddr),
    .rdata_o (dout_o)
  );

  txn_fifo_level #(.ADDR_W(ADDR_W), .BITS(FILL_B), .OUT_W(FILL_OW)) u_fill (
    .cnt_i (fill_cnt),
    .lvl_o (fill_lvl_o)
  );

  txn_fifo_level #(.ADDR_W(ADDR_W), .BITS(FREE_B), .OUT_W(FREE_OW)) u_free (
    .cnt_i (free_cnt),
    .lvl_o (free_lvl_o)
  );
endmodule

// File: rtl/txn_fifo_chk.sv
module txn_fifo_chk #(
  parameter int unsigned FILL_OW = 2,
  parameter int unsigned FREE_OW = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               got_i,
  input logic               commit_i,
  input logic               rollback_i,
  input logic               full_o,
  input logic               valid_o,
  input logic [FILL_OW-1:0] fill_lvl_o,
  input logic [FREE_OW-1:0] free_lvl_o
);
  assert_pending_hidden_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !valid_o) |=> !valid_o);

  assert_committed_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !got_i) |=> valid_o);

  assert_full_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !got_i && !rollback_i) |=> full_o);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !got_i && !rollback_i) |=> $stable(free_lvl_o));

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !commit_i) |=> $stable(fill_lvl_o));

  assert_empty_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (fill_lvl_o == '0));

  assert_full_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (free_lvl_o == '0));
endmodule

bind txn_fifo txn_fifo_chk #(.FILL_OW(FILL_OW), .FREE_OW(FREE_OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .got_i      (got_i),
  .commit_i   (commit_i),
  .rollback_i (rollback_i),
  .full_o     (full_o),
  .valid_o    (valid_o),
  .fill_lvl_o (fill_lvl_o),
  .free_lvl_o (free_lvl_o)
);

// File: tb/txn_fifo_tb_top.sv
module txn_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;  // MIN_DEPTH 12 rounded up

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       put_i = 1'b0, got_i = 1'b0, commit_i = 1'b0, rollback_i = 1'b0;
  logic [7:0] din_i = '0;
  logic [7:0] dout_o;
  logic       full_o, valid_o;
  logic [1:0] fill_lvl_o, free_lvl_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cq[$];
  logic [7:0] pq[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  txn_fifo #(.DATA_W(8), .MIN_DEPTH(12), .FILL_BITS(2), .FREE_BITS(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .put_i(put_i), .din_i(din_i),
    .commit_i(commit_i), .rollback_i(rollback_i), .full_o(full_o),
    .free_lvl_o(free_lvl_o), .got_i(got_i), .dout_o(dout_o),
    .valid_o(valid_o), .fill_lvl_o(fill_lvl_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int quant(input int cnt);
    int q = cnt * 4 / DEPTH;
    return (q > 3) ? 3 : q;
  endfunction

  task automatic check_all();
    chk("R3 valid", int'(valid_o), int'(cq.size() != 0));
    chk("R5 full", int'(full_o), int'(cq.size() + pq.size() == DEPTH));
    if (cq.size() != 0) chk("R3 dout", int'(dout_o), int'(cq[0]));
    chk("R9 fill level", int'(fill_lvl_o), quant(cq.size()));
    chk("R10 free level", int'(free_lvl_o), quant(DEPTH - cq.size() - pq.size()));
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic p, input logic [7:0] d, input logic g,
                      input logic c, input logic r);
    bit f  = (cq.size() + pq.size()) == DEPTH;
    bit dp = p && !f;
    bit dg = g && (cq.size() != 0);
    put_i = p; din_i = d; got_i = g; commit_i = c; rollback_i = r;
    @(posedge clk_i);
    if (dg) void'(cq.pop_front());
    if (dp) pq.push_back(d);
    if (c) begin
      foreach (pq[i]) cq.push_back(pq[i]);
      pq.delete();
    end
    if (r) pq.delete();
    @(negedge clk_i);
    put_i = 0; got_i = 0; commit_i = 0; rollback_i = 0;
    check_all();
  endtask

  task automatic drain();
    while (cq.size() != 0) step(0, 0, 1, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 full", int'(full_o), 0);
    chk("R1 fill", int'(fill_lvl_o), 0);
    chk("R1 free", int'(free_lvl_o), 3);
  endtask

  task automatic t_pending_hidden();
    for (int i = 0; i < 3; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
    chk("R2 pending not valid", int'(valid_o), 0);
    step(1, 8'h13, 0, 1, 0);  // commit with same-cycle put
    chk("R3 committed count valid", int'(valid_o), 1);
    chk("R3 head", int'(dout_o), 8'h10);
    for (int i = 0; i < 4; i++) begin
      chk("R3 order", int'(dout_o), 8'h10 + i);
      step(0, 0, 1, 0, 0);
    end
    chk("R3 drained", int'(valid_o), 0);
  endtask

  task automatic t_rollback();
    step(1, 8'hA0, 0, 0, 0);
    step(1, 8'hA1, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 8'hB0 + 8'(i), 0, 0, 0);
    step(1, 8'hB3, 0, 0, 1);  // rollback with same-cycle put
    chk("R4 committed head", int'(dout_o), 8'hA0);
    chk("R4 free level", int'(free_lvl_o), 3);
    for (int i = 0; i < 14; i++) step(1, 8'hC0 + 8'(i), 0, 0, 0);
    chk("R4 space reused full", int'(full_o), 1);
    step(0, 0, 0, 0, 1);
    chk("R4 rollback frees", int'(full_o), 0);
    step(0, 0, 1, 0, 0);
    chk("R4 second word", int'(dout_o), 8'hA1);
    step(0, 0, 1, 0, 0);
    chk("R4 nothing left", int'(valid_o), 0);
  endtask

  task automatic t_full_overflow();
    for (int i = 0; i < DEPTH - 1; i++) step(1, 8'h40 + 8'(i), 0, 0, 0);
    chk("R11 not full at 15", int'(full_o), 0);
    step(1, 8'h4F, 0, 0, 0);
    chk("R11 full at 16", int'(full_o), 1);
    chk("R5 full while not valid", int'(valid_o), 0);
    step(1, 8'hEE, 0, 1, 0);  // put while full, with commit
    chk("R6 still full", int'(full_o), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 data intact", int'(dout_o), 8'h40 + i);
      step(0, 0, 1, 0, 0);
    end
    chk("R6 no extra word", int'(valid_o), 0);
  endtask

  task automatic t_underflow();
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 8'h77, 0, 1, 0);
    chk("R7 got on empty ignored", int'(dout_o), 8'h77);
    drain();
  endtask

  task automatic t_simul();
    step(1, 8'h01, 0, 0, 0);
    step(1, 8'h02, 0, 1, 0);
    step(1, 8'h03, 1, 1, 0);
    chk("R8 head after pop", int'(dout_o), 8'h02);
    chk("R8 level", int'(cq.size()), 2);
    step(0, 0, 1, 0, 0);
    chk("R8 pushed word", int'(dout_o), 8'h03);
    drain();
  endtask

  task automatic t_levels();
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 8'(i), 0, 1, 0);
      if (i == 3)  chk("R9 quarter", int'(fill_lvl_o), 1);
      if (i == 7)  chk("R9 half", int'(fill_lvl_o), 2);
      if (i == 11) chk("R10 quarter free", int'(free_lvl_o), 1);
    end
    chk("R9 saturate", int'(fill_lvl_o), 3);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();
    t_pending_hidden();
    t_rollback();
    t_full_overflow();
    t_underflow();
    t_simul();
    t_levels();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule